// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block orders the two bulk transfers of a serial memory that keeps its working data in SRAM backed by a nonvolatile array. A store copies the SRAM image into the nonvolatile cells in two phases: the old nonvolatile contents are erased first, then the new image is programmed. A recall brings the image back in two phases: the SRAM is wiped first, then the nonvolatile contents are transferred into it. Fixed cycle counters set the length of every phase, and the array itself is modelled only by the four phase strobes.

A store can start in three ways: a software strobe, a power-fail flag (automatic store), or an external master pulling the shared open-drain busy pin low (hardware store). The automatic and hardware stores are conditional and run only if the SRAM has accepted a write since the last completed store or recall. The software store always runs. A recall starts once the supply is good after reset, or on a software strobe. While a transfer runs, memory access is inhibited and the busy flag is set. The shared pin is pulled low during every store and during the power-up recall, but not during a software recall. After any store, access stays inhibited until the shared pin reads high again.

Top module: `nv_store_seq`

## Requirements
- R1: While reset is held, and after reset until `pwr_good` is high, `inhibit` is 1, and `busy`, `hsb_drive_low` and all four phase strobes are 0. Once `pwr_good` rises, a recall runs, with `hsb_drive_low` high throughout it. After the recall the block is idle with `inhibit` at 0.
- R2: A recall asserts `sram_clear` for CLEAR_CYC cycles, then `nv_transfer` for XFER_CYC cycles. It never asserts `nv_erase` or `nv_program`. At most one phase strobe is high in any cycle.
- R3: A store asserts `nv_erase` for ERASE_CYC cycles, then `nv_program` for PROG_CYC cycles. `hsb_drive_low` is high in every store cycle. A software store runs whether or not a write has occurred.
- R4: A `wr_pulse` sets the dirty state only when `inhibit` is 0. The dirty state is cleared when a store or recall completes. It is seen at the ports through whether a conditional store runs.
- R5: The shared pin sampled low while idle starts a delay of HSB_DLY cycles, with `inhibit` high and `busy` low. At the end of the delay a store starts if the block is dirty.
- R6: A hardware request while clean runs no store. `inhibit` stays high until the delay has elapsed and the pin has been seen high.
- R7: After any store other than an automatic one, `inhibit` stays high with `busy` low until the shared pin is sampled high. The block then returns to idle.
- R8: `pwr_fail` while idle starts a store only if automatic store is enabled and the block is dirty. Either way the block then enters a power-off state with `inhibit` 1 and `busy` 0, and stays there until reset.
- R9: `as_disable` turns automatic store off and `as_enable` turns it back on. Reset leaves it enabled. If both strobes are high in the same cycle, disable wins.
- R10: A software recall sets `busy` but never drives `hsb_drive_low`.
- R11: When several requests arrive in the same idle cycle, the priority order is `pwr_fail`, then the pin low, then `sw_store`, then `sw_recall`. Store and recall strobes that arrive while the block is not idle are ignored.
- R12: `busy` is high exactly during the erase, program, clear and transfer phases, and `busy` implies `inhibit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| pwr_fail | input | 1 | Supply comparator: supply below the switch threshold |
| pwr_good | input | 1 | Supply valid after power-up |
| hsb_n_in | input | 1 | Sampled level of the shared busy/request pin (low = request or busy) |
| sw_store | input | 1 | Software store strobe |
| sw_recall | input | 1 | Software recall strobe |
| as_enable | input | 1 | Automatic store enable strobe |
| as_disable | input | 1 | Automatic store disable strobe |
| wr_pulse | input | 1 | One SRAM write took place |
| busy | output | 1 | Transfer in progress (status bit) |
| hsb_drive_low | output | 1 | Open-drain pull-down enable for the shared pin |
| inhibit | output | 1 | Memory access blocked |
| nv_erase | output | 1 | Erase phase of a store |
| nv_program | output | 1 | Program phase of a store |
| sram_clear | output | 1 | SRAM wipe phase of a recall |
| nv_transfer | output | 1 | Nonvolatile-to-SRAM transfer phase of a recall |

## Verification
The hardest situation to reach is one where the dirty state decides the outcome while the write that would set it is refused because the block is inhibited. The stimulus holds `wr_pulse` high through a whole hardware-request window, then issues a second hardware request. The second request must still run no store. The pin is modelled as a wired-AND of the block's pull-down and an external holder, so the wait after a store and a long external hold can both be timed. Automatic store is reached by raising `pwr_fail` after combinations of enable, disable and write, with a reset between cases to leave the power-off state.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  typedef enum logic [3:0] {
    ST_PORW  = 4'd0,
    ST_IDLE  = 4'd1,
    ST_HWDLY = 4'd2,
    ST_ERASE = 4'd3,
    ST_PROG  = 4'd4,
    ST_CLEAR = 4'd5,
    ST_XFER  = 4'd6,
    ST_HOLD  = 4'd7,
    ST_OFF   = 4'd8
  } seq_st_t;

  function automatic int unsigned max5(int unsigned a, int unsigned b, int unsigned c,
                                       int unsigned d, int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

  // Cycles a timed state lasts; 1 for untimed states (counter never enabled there).
  function automatic int unsigned phase_cycles(seq_st_t s, int unsigned er, int unsigned pr,
                                               int unsigned cl, int unsigned xf,
                                               int unsigned dl);
    case (s)
      ST_ERASE: return er;
      ST_PROG:  return pr;
      ST_CLEAR: return cl;
      ST_XFER:  return xf;
      ST_HWDLY: return dl;
      default:  return 1;
    endcase
  endfunction

  function automatic logic is_timed(seq_st_t s);
    return (s == ST_ERASE) || (s == ST_PROG) || (s == ST_CLEAR) ||
           (s == ST_XFER) || (s == ST_HWDLY);
  endfunction

endpackage

// File: rtl/nv_phase_timer.sv
module nv_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          en,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (en)      cnt <= cnt + 1'b1;
  end

  assign last = en && (cnt == len - 1'b1);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < len)); // R2

endmodule

// File: rtl/nv_dirty_track.sv
module nv_dirty_track (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_pulse,
  input  logic inhibit,
  input  logic op_done,
  input  logic as_on,
  input  logic as_off,
  output logic dirty,
  output logic as_en
);
  logic wr_accept;
  assign wr_accept = wr_pulse && !inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty <= 1'b0;
      as_en <= 1'b1;
    end else begin
      if (op_done)        dirty <= 1'b0;
      else if (wr_accept) dirty <= 1'b1;
      if (as_off)         as_en <= 1'b0;
      else if (as_on)     as_en <= 1'b1;
    end
  end

  AST_DIRTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> dirty); // R4
  AST_DIRTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !dirty); // R4
  AST_AS_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    as_off |=> !as_en); // R9

endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq
  import nvseq_pkg::*;
#(
  parameter int unsigned ERASE_CYC = 4,
  parameter int unsigned PROG_CYC  = 6,
  parameter int unsigned CLEAR_CYC = 3,
  parameter int unsigned XFER_CYC  = 5,
  parameter int unsigned HSB_DLY   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic pwr_good,
  input  logic hsb_n_in,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic as_enable,
  input  logic as_disable,
  input  logic wr_pulse,
  output logic busy,
  output logic hsb_drive_low,
  output logic inhibit,
  output logic nv_erase,
  output logic nv_program,
  output logic sram_clear,
  output logic nv_transfer
);
  localparam int unsigned MAXC = max5(ERASE_CYC, PROG_CYC, CLEAR_CYC, XFER_CYC, HSB_DLY);
  localparam int CW = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  seq_st_t st, st_nxt;
  logic    por_rcl, from_auto;
  logic    dirty, as_en, op_done, ph_last;
  logic    go_auto, go_por, go_swrcl, go_store_other;
  logic [CW-1:0] ph_len;

  assign ph_len = CW'(phase_cycles(st, ERASE_CYC, PROG_CYC, CLEAR_CYC, XFER_CYC, HSB_DLY));

  nv_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (st_nxt != st),
    .en      (is_timed(st)),
    .len     (ph_len),
    .last    (ph_last)
  );

  assign op_done = ph_last && ((st == ST_PROG) || (st == ST_XFER));

  nv_dirty_track u_dirty (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_pulse (wr_pulse),
    .inhibit  (inhibit),
    .op_done  (op_done),
    .as_on    (as_enable),
    .as_off   (as_disable),
    .dirty    (dirty),
    .as_en    (as_en)
  );

  always_comb begin
    st_nxt         = st;
    go_auto        = 1'b0;
    go_por         = 1'b0;
    go_swrcl       = 1'b0;
    go_store_other = 1'b0;
    case (st)
      ST_PORW: if (pwr_good) begin st_nxt = ST_CLEAR; go_por = 1'b1; end
      ST_IDLE: begin
        if (pwr_fail) begin
          if (as_en && dirty) begin st_nxt = ST_ERASE; go_auto = 1'b1; end
          else st_nxt = ST_OFF;
        end else if (!hsb_n_in) st_nxt = ST_HWDLY;
        else if (sw_store) begin st_nxt = ST_ERASE; go_store_other = 1'b1; end
        else if (sw_recall) begin st_nxt = ST_CLEAR; go_swrcl = 1'b1; end
      end
      ST_HWDLY: if (ph_last) begin
        if (dirty) begin st_nxt = ST_ERASE; go_store_other = 1'b1; end
        else st_nxt = ST_HOLD;
      end
      ST_ERASE: if (ph_last) st_nxt = ST_PROG;
      ST_PROG:  if (ph_last) st_nxt = from_auto ? ST_OFF : ST_HOLD;
      ST_CLEAR: if (ph_last) st_nxt = ST_XFER;
      ST_XFER:  if (ph_last) st_nxt = ST_IDLE;
      ST_HOLD:  if (hsb_n_in) st_nxt = ST_IDLE;
      ST_OFF:   st_nxt = ST_OFF;
      default:  st_nxt = ST_PORW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_PORW;
      por_rcl   <= 1'b0;
      from_auto <= 1'b0;
    end else begin
      st <= st_nxt;
      if (go_por)              por_rcl   <= 1'b1;
      else if (go_swrcl)       por_rcl   <= 1'b0;
      if (go_auto)             from_auto <= 1'b1;
      else if (go_store_other) from_auto <= 1'b0;
    end
  end

  assign nv_erase      = (st == ST_ERASE);
  assign nv_program    = (st == ST_PROG);
  assign sram_clear    = (st == ST_CLEAR);
  assign nv_transfer   = (st == ST_XFER);
  assign busy          = nv_erase | nv_program | sram_clear | nv_transfer;
  assign inhibit       = (st != ST_IDLE);
  assign hsb_drive_low = nv_erase | nv_program | ((sram_clear | nv_transfer) & por_rcl);

  AST_PIN_LOW_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_erase || nv_program) |-> hsb_drive_low); // R3
  AST_ERASE_BEFORE_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_program) |-> $past(nv_erase)); // R3
  AST_CLEAR_BEFORE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_transfer) |-> $past(sram_clear)); // R2
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nv_erase, nv_program, sram_clear, nv_transfer})); // R2
  AST_BUSY_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> inhibit); // R12
  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && !hsb_n_in) |=> inhibit); // R7
  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF) |=> (inhibit && !busy)); // R8
  AST_SWREC_PIN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !pwr_fail && hsb_n_in && !sw_store && sw_recall) |=> !hsb_drive_low); // R10

endmodule

// File: tb/nv_store_seq_tb.sv
module nv_store_seq_tb;
  localparam int E = 4, P = 6, C = 3, X = 5, D = 3;

  logic clk = 1'b0;
  logic rst_n, pwr_fail, pwr_good, sw_store, sw_recall, as_enable, as_disable, wr_pulse;
  logic ext_hold;
  logic busy, hsb_drive_low, inhibit, nv_erase, nv_program, sram_clear, nv_transfer;
  wire  hsb_pin = ~(hsb_drive_low | ext_hold);

  int checks = 0, fails = 0, cyc = 0;
  int nE, nP, nC, nX, nD, nNB, eL, pF, cL, xF;
  bit ended;

  always #10 clk = ~clk;

  nv_store_seq #(.ERASE_CYC(E), .PROG_CYC(P), .CLEAR_CYC(C), .XFER_CYC(X), .HSB_DLY(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .pwr_good(pwr_good), .hsb_n_in(hsb_pin),
    .sw_store(sw_store), .sw_recall(sw_recall), .as_enable(as_enable), .as_disable(as_disable),
    .wr_pulse(wr_pulse), .busy(busy), .hsb_drive_low(hsb_drive_low), .inhibit(inhibit),
    .nv_erase(nv_erase), .nv_program(nv_program), .sram_clear(sram_clear), .nv_transfer(nv_transfer));

  task automatic chk(input string r, input int a, input int e);
    checks++;
    if (a != e) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, a, e);
    end
  endtask

  task automatic watch(input int hold_len, input bit inj, input bit wr_in, input int limit);
    nE = 0; nP = 0; nC = 0; nX = 0; nD = 0; nNB = 0;
    eL = -1; pF = -1; cL = -1; xF = -1; ended = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!inhibit) begin ended = 1; break; end
      if (nv_erase)    begin nE++; eL = i; end
      if (nv_program)  begin nP++; if (pF < 0) pF = i; end
      if (sram_clear)  begin nC++; cL = i; end
      if (nv_transfer) begin nX++; if (xF < 0) xF = i; end
      if (hsb_drive_low) nD++;
      if (!busy) nNB++;
      if (i == 0) begin
        sw_store = 0; sw_recall = 0; as_enable = 0; as_disable = 0; wr_pulse = wr_in;
      end
      if (i + 1 >= hold_len) ext_hold = 0;
      if (inj && i == 2) sw_recall = 1;
      if (inj && i == 3) sw_recall = 0;
    end
    sw_store = 0; sw_recall = 0; as_enable = 0; as_disable = 0; wr_pulse = 0; ext_hold = 0;
  endtask

  task automatic expect_run(input string r, input int e, input int p, input int c, input int x,
                            input int d, input int nb, input bit en_end);
    chk({r, " erase cycles"}, nE, e);
    chk({r, " program cycles"}, nP, p);
    chk({r, " clear cycles"}, nC, c);
    chk({r, " transfer cycles"}, nX, x);
    chk({r, " pin drive cycles"}, nD, d);
    chk({r, " inhibit-not-busy cycles"}, nNB, nb);
    chk({r, " phase order"}, int'((pF < 0 || eL < pF) && (xF < 0 || cL < xF)), 1);
    chk({r, " returned idle"}, int'(ended), int'(en_end));
  endtask

  task automatic do_write();
    @(negedge clk); wr_pulse = 1;
    @(negedge clk); wr_pulse = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pwr_fail = 0; pwr_good = 0; ext_hold = 0;
    sw_store = 0; sw_recall = 0; as_enable = 0; as_disable = 0; wr_pulse = 0;
    repeat (2) @(negedge clk);
    chk("R1 inhibit in reset", int'(inhibit), 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 inhibit before pwr_good", int'(inhibit), 1);
    chk("R1 no busy before pwr_good", int'(busy | hsb_drive_low | sram_clear | nv_erase), 0);
    pwr_good = 1;
    watch(0, 0, 0, 60);
    expect_run("R1 R2 power-up recall", 0, 0, C, X, C + X, 0, 1);
  endtask

  initial begin
    rst_n = 0;
    do_reset();

    // Sweep: dirty state x trigger kind (0 sw store, 1 hw pin, 2 sw recall)
    for (int dty = 0; dty < 2; dty++) begin
      for (int trig = 0; trig < 3; trig++) begin
        if (dty == 1) do_write();
        @(negedge clk);
        if (trig == 0) begin
          sw_store = 1;
          watch(1, 0, 0, 60);
          expect_run("R3 R7 software store", E, P, 0, 0, E + P, 1, 1);
        end else if (trig == 1) begin
          ext_hold = 1;
          watch(1, 0, 0, 60);
          if (dty == 1) expect_run("R5 hardware store dirty", E, P, 0, 0, E + P, D + 1, 1);
          else          expect_run("R6 R4 hardware request clean", 0, 0, 0, 0, 0, D + 1, 1);
        end else begin
          sw_recall = 1;
          watch(1, 0, 0, 60);
          expect_run("R10 software recall", 0, 0, C, X, 0, 0, 1);
        end
      end
    end

    // R6: long external hold while clean
    @(negedge clk); ext_hold = 1;
    watch(10, 0, 0, 60);
    expect_run("R6 long hold clean", 0, 0, 0, 0, 0, 10, 1);

    // R4: writes while inhibited are refused
    @(negedge clk); ext_hold = 1;
    watch(1, 0, 1, 60);
    expect_run("R4 write during inhibit", 0, 0, 0, 0, 0, D + 1, 1);
    @(negedge clk); ext_hold = 1;
    watch(1, 0, 0, 60);
    expect_run("R4 still clean afterwards", 0, 0, 0, 0, 0, D + 1, 1);

    // R11: store beats recall; recall during store ignored
    @(negedge clk); sw_store = 1; sw_recall = 1;
    watch(1, 1, 0, 60);
    expect_run("R11 store over recall, late recall ignored", E, P, 0, 0, E + P, 1, 1);
    repeat (2) @(negedge clk);
    chk("R11 no deferred recall", int'(inhibit), 0);

    // R11: pin beats software store (clean, so no store)
    @(negedge clk); ext_hold = 1; sw_store = 1;
    watch(1, 0, 0, 60);
    expect_run("R11 pin over sw store", 0, 0, 0, 0, 0, D + 1, 1);

    // R9: disabled autostore, dirty -> no store, power-off
    @(negedge clk); as_disable = 1;
    @(negedge clk); as_disable = 0;
    do_write();
    @(negedge clk); pwr_fail = 1;
    watch(0, 0, 0, 30);
    expect_run("R9 R8 autostore disabled", 0, 0, 0, 0, 0, 30, 0);
    do_reset();

    // R9: enable and disable together -> disabled
    @(negedge clk); as_disable = 1; as_enable = 1;
    @(negedge clk); as_disable = 0; as_enable = 0;
    do_write();
    @(negedge clk); pwr_fail = 1;
    watch(0, 0, 0, 30);
    expect_run("R9 disable wins", 0, 0, 0, 0, 0, 30, 0);
    do_reset();

    // R8: clean with autostore enabled -> no store
    @(negedge clk); pwr_fail = 1;
    watch(0, 0, 0, 30);
    expect_run("R8 autostore clean", 0, 0, 0, 0, 0, 30, 0);
    do_reset();

    // R8 R9 R11: default enabled, dirty, pwr_fail together with pin low -> autostore then off
    do_write();
    @(negedge clk); pwr_fail = 1; ext_hold = 1;
    watch(1, 0, 0, 30);
    expect_run("R8 R11 autostore default enabled", E, P, 0, 0, E + P, 30 - E - P, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule